// File: doc/BRIEF.md
# Paged Monochrome Display Frame Store

This block sits behind a processor register port and stands in for a small serially attached monochrome panel controller with a 128 by 64 pixel grid. Software selects one of two operating modes through a mode register, points a cursor at a page, and then streams bytes through a data register. Each byte covers eight vertically stacked pixels of one column within a page of eight rows. The block keeps the whole picture in a page-organized byte store.

A scan-out engine fetches single pixels through a separate read port, giving a column and row. The pixel value comes back one clock later. Register writes and scan-out reads use separate memory ports, so neither one ever waits for the other. A 32-bit interrupt-control register is held for software. Every other register reads back as zero.

Top module: `mono_panel_ctrl`

## Requirements
- R1: After reset, the mode is invalid, the cursor is at page 0 and column 0, the interrupt-control register holds 0, and `rdata` is 0. A data write issued right after reset stores nothing. The first store after data mode is entered goes to page 0, column 0.
- R2: A write to offset 0x180 sets the 32-bit interrupt-control register. A read of 0x180 with `rd_en` high returns that value on `rdata` one cycle later.
- R3: A read of any offset other than 0x180 returns 0 on `rdata`. This includes the mode, instruction and data offsets.
- R4: A write to the mode offset 0x1AC of exactly 0x00100011 selects data mode. Exactly 0x00104011 selects command mode. Any other value selects the invalid mode.
- R5: A write to the instruction offset 0x1BC of a value from 0xB0 to 0xB7, compared over all 32 bits, moves the cursor to page (value − 0xB0) and column 0. This works in every mode. Any other value leaves the cursor unchanged.
- R6: In command mode, a write to the data offset 0x1C0 of 0xB0 to 0xB7 selects a page exactly as in R5. Other values change neither the cursor nor the store.
- R7: In data mode, a write to the data offset stores `wdata[7:0]` at byte index page × 128 + column. The column then advances by one.
- R8: A data-mode store at column 127 wraps the column to 0 and leaves the page unchanged.
- R9: In the invalid mode, writes to the data offset change neither the store nor the cursor.
- R10: When `scan_en` is high with (`scan_x`, `scan_y`), `scan_pix` shows bit (`scan_y` mod 8) of byte `scan_x` + (`scan_y` / 8) × 128 in the following cycle.
- R11: A scan read and a data store to a different byte in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 12 | Register byte offset |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, valid one cycle after `rd_en` |
| scan_en | input | 1 | Scan-out pixel fetch request |
| scan_x | input | 7 | Scan-out column, 0 to 127 |
| scan_y | input | 6 | Scan-out row, 0 to 63 |
| scan_pix | output | 1 | Fetched pixel, one cycle after `scan_en` |

## Verification
The assertions assume the following about the inputs:
- Reset is held for at least one clock edge before the checks begin.
- `rd_en` and `wr_en` are never both high in the same cycle, since they share one address.
- A scan read never targets the byte being stored in that same cycle.

The stimulus keeps every register access in a cycle of its own. Its only overlapped cycle pairs a scan of page 0 with a store into page 6. Expected memory contents come from an arithmetic fill pattern, and every byte is swept back pixel by pixel.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_DATA = 2'd1,
    MODE_CMD  = 2'd2
  } lcdp_mode_e;

  localparam logic [31:0] MAGIC_DATA    = 32'h0010_0011;
  localparam logic [31:0] MAGIC_CMD     = 32'h0010_4011;
  localparam logic [31:0] PAGE_CMD_BASE = 32'h0000_00B0;

  localparam int SLOT_IRQ  = 0;
  localparam int SLOT_MODE = 1;
  localparam int SLOT_INST = 2;
  localparam int SLOT_DATA = 3;
  localparam int NUM_SLOTS = 4;
endpackage

// File: rtl/lcdp_decode.sv
module lcdp_decode
  import lcdp_pkg::*;
#(
  parameter int AW = 12,
  parameter logic [AW-1:0] OFF_IRQ  = 'h180,
  parameter logic [AW-1:0] OFF_MODE = 'h1AC,
  parameter logic [AW-1:0] OFF_INST = 'h1BC,
  parameter logic [AW-1:0] OFF_DATA = 'h1C0
) (
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  logic [AW-1:0]        addr,
  output logic [NUM_SLOTS-1:0] wr_hit,
  output logic                 rd_irq
);
  localparam logic [AW-1:0] OFFS [NUM_SLOTS] = '{OFF_IRQ, OFF_MODE, OFF_INST, OFF_DATA};

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    assign wr_hit[i] = wr_en && (addr == OFFS[i]);
  end

  assign rd_irq = rd_en && (addr == OFF_IRQ);
endmodule

// File: rtl/lcdp_cursor.sv
module lcdp_cursor
  import lcdp_pkg::*;
#(
  parameter int PAGES = 8,
  parameter int COLS  = 128,
  localparam int PG_W  = $clog2(PAGES),
  localparam int COL_W = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_mode,
  input  logic             hit_inst,
  input  logic             hit_data,
  input  logic [31:0]      wdata,
  output lcdp_mode_e       mode_q,
  output logic [PG_W-1:0]  page_q,
  output logic [COL_W-1:0] col_q
);
  localparam logic [31:0] PAGE_CMD_END = PAGE_CMD_BASE + 32'(PAGES);

  logic       page_cmd;
  logic       page_sel;
  logic       store;
  lcdp_mode_e mode_nx;

  assign page_cmd = (wdata >= PAGE_CMD_BASE) && (wdata < PAGE_CMD_END);
  assign page_sel = page_cmd && (hit_inst || (hit_data && mode_q == MODE_CMD));
  assign store    = hit_data && (mode_q == MODE_DATA);

  always_comb begin
    if (wdata == MAGIC_DATA)     mode_nx = MODE_DATA;
    else if (wdata == MAGIC_CMD) mode_nx = MODE_CMD;
    else                         mode_nx = MODE_OFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_OFF;
      page_q <= '0;
      col_q  <= '0;
    end else begin
      if (hit_mode) mode_q <= mode_nx;
      if (page_sel) begin
        page_q <= PG_W'(wdata - PAGE_CMD_BASE);
        col_q  <= '0;
      end else if (store) begin
        if (col_q == COL_W'(COLS - 1)) col_q <= '0;
        else                           col_q <= col_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/lcdp_vram.sv
module lcdp_vram #(
  parameter int DEPTH = 1024,
  parameter int W     = 8,
  localparam int MAW  = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           we,
  input  logic [MAW-1:0] waddr,
  input  logic [W-1:0]   wbyte,
  input  logic           re,
  input  logic [MAW-1:0] raddr,
  output logic [W-1:0]   rbyte
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wbyte;
  end

  always_ff @(posedge clk) begin
    if (re) rbyte <= mem[raddr];
  end
endmodule

// File: rtl/mono_panel_ctrl.sv
module mono_panel_ctrl
  import lcdp_pkg::*;
#(
  parameter int AW    = 12,
  parameter int PAGES = 8,
  parameter int COLS  = 128,
  parameter logic [AW-1:0] OFF_IRQ  = 'h180,
  parameter logic [AW-1:0] OFF_MODE = 'h1AC,
  parameter logic [AW-1:0] OFF_INST = 'h1BC,
  parameter logic [AW-1:0] OFF_DATA = 'h1C0,
  localparam int PG_W  = $clog2(PAGES),
  localparam int COL_W = $clog2(COLS),
  localparam int ROW_W = PG_W + 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             scan_en,
  input  logic [COL_W-1:0] scan_x,
  input  logic [ROW_W-1:0] scan_y,
  output logic             scan_pix
);
  localparam int DEPTH = PAGES * COLS;
  localparam int MAW   = $clog2(DEPTH);

  logic [NUM_SLOTS-1:0] wr_hit;
  logic                 rd_irq;
  lcdp_mode_e           cur_mode;
  logic [PG_W-1:0]      cur_page;
  logic [COL_W-1:0]     cur_col;
  logic [31:0]          irq_ctrl_q;
  logic                 mem_we;
  logic [MAW-1:0]       mem_waddr;
  logic [MAW-1:0]       mem_raddr;
  logic [7:0]           scan_byte;
  logic [2:0]           bit_q;

  lcdp_decode #(
    .AW(AW), .OFF_IRQ(OFF_IRQ), .OFF_MODE(OFF_MODE),
    .OFF_INST(OFF_INST), .OFF_DATA(OFF_DATA)
  ) u_decode (
    .wr_en (wr_en),
    .rd_en (rd_en),
    .addr  (addr),
    .wr_hit(wr_hit),
    .rd_irq(rd_irq)
  );

  lcdp_cursor #(.PAGES(PAGES), .COLS(COLS)) u_cursor (
    .clk     (clk),
    .rst     (rst),
    .hit_mode(wr_hit[SLOT_MODE]),
    .hit_inst(wr_hit[SLOT_INST]),
    .hit_data(wr_hit[SLOT_DATA]),
    .wdata   (wdata),
    .mode_q  (cur_mode),
    .page_q  (cur_page),
    .col_q   (cur_col)
  );

  assign mem_we    = wr_hit[SLOT_DATA] && (cur_mode == MODE_DATA);
  assign mem_waddr = MAW'(MAW'(cur_page) * MAW'(COLS) + MAW'(cur_col));
  assign mem_raddr = MAW'(MAW'(scan_y[ROW_W-1:3]) * MAW'(COLS) + MAW'(scan_x));

  lcdp_vram #(.DEPTH(DEPTH), .W(8)) u_vram (
    .clk  (clk),
    .we   (mem_we),
    .waddr(mem_waddr),
    .wbyte(wdata[7:0]),
    .re   (scan_en),
    .raddr(mem_raddr),
    .rbyte(scan_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) bit_q <= '0;
    else if (scan_en) bit_q <= scan_y[2:0];
  end

  assign scan_pix = scan_byte[bit_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ctrl_q <= '0;
      rdata      <= '0;
    end else begin
      if (wr_hit[SLOT_IRQ]) irq_ctrl_q <= wdata;
      rdata <= rd_irq ? irq_ctrl_q : '0;
    end
  end
endmodule

// File: rtl/lcdp_chk.sv
module lcdp_chk
  import lcdp_pkg::*;
#(
  parameter int AW    = 12,
  parameter int PAGES = 8,
  parameter int COLS  = 128,
  parameter logic [AW-1:0] OFF_IRQ  = 'h180,
  parameter logic [AW-1:0] OFF_MODE = 'h1AC,
  parameter logic [AW-1:0] OFF_INST = 'h1BC,
  parameter logic [AW-1:0] OFF_DATA = 'h1C0,
  localparam int PG_W  = $clog2(PAGES),
  localparam int COL_W = $clog2(COLS)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic             rd_en,
  input logic [AW-1:0]    addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input lcdp_mode_e       mode,
  input logic [PG_W-1:0]  page,
  input logic [COL_W-1:0] col
);
  localparam logic [31:0] PEND = PAGE_CMD_BASE + 32'(PAGES);

  // R5
  inst_page_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_INST && wdata >= PAGE_CMD_BASE && wdata < PEND)
    |=> (page == PG_W'($past(wdata) - PAGE_CMD_BASE) && col == '0));

  // R6
  cmd_page_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_DATA && mode == MODE_CMD && wdata >= PAGE_CMD_BASE && wdata < PEND)
    |=> (page == PG_W'($past(wdata) - PAGE_CMD_BASE) && col == '0));

  // R7
  store_step_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_DATA && mode == MODE_DATA && col != COL_W'(COLS - 1))
    |=> (col == $past(col) + 1'b1 && $stable(page)));

  // R8
  col_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_DATA && mode == MODE_DATA && col == COL_W'(COLS - 1))
    |=> (col == '0 && $stable(page)));

  // R9
  off_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_DATA && mode == MODE_OFF)
    |=> ($stable(page) && $stable(col)));

  // R4
  mode_reject_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == OFF_MODE && wdata != MAGIC_DATA && wdata != MAGIC_CMD)
    |=> (mode == MODE_OFF));

  // R3
  rdata_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr != OFF_IRQ) |=> (rdata == '0));
endmodule

bind mono_panel_ctrl lcdp_chk #(
  .AW(AW), .PAGES(PAGES), .COLS(COLS),
  .OFF_IRQ(OFF_IRQ), .OFF_MODE(OFF_MODE), .OFF_INST(OFF_INST), .OFF_DATA(OFF_DATA)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .mode(cur_mode), .page(cur_page), .col(cur_col)
);

// File: tb/tb_mono_panel_ctrl.sv
`timescale 1ns/1ps
module tb_mono_panel_ctrl;
  localparam int AW = 12;
  localparam int PAGES = 8;
  localparam int COLS = 128;
  localparam int DEPTH = PAGES * COLS;
  localparam logic [AW-1:0] A_IRQ  = 12'h180;
  localparam logic [AW-1:0] A_MODE = 12'h1AC;
  localparam logic [AW-1:0] A_INST = 12'h1BC;
  localparam logic [AW-1:0] A_DATA = 12'h1C0;
  localparam logic [31:0] M_DATA = 32'h0010_0011;
  localparam logic [31:0] M_CMD  = 32'h0010_4011;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst, wr_en, rd_en, scan_en, scan_pix;
  logic [AW-1:0] addr;
  logic [31:0]   wdata, rdata;
  logic [6:0]    scan_x;
  logic [5:0]    scan_y;

  int  checks = 0;
  int  errors = 0;
  bit  done = 1'b0;
  logic [7:0] exp_mem [DEPTH];

  mono_panel_ctrl dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .scan_en(scan_en), .scan_x(scan_x),
    .scan_y(scan_y), .scan_pix(scan_pix)
  );

  function automatic logic [7:0] pat(int p, int c);
    return 8'(p * 37 + c * 11 + 7);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic scan_byte(input int p, input int c, output logic [7:0] b);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      scan_en = 1'b1; scan_x = 7'(c); scan_y = 6'(p * 8 + k);
      @(negedge clk);
      scan_en = 1'b0;
      b[k] = scan_pix;
    end
  endtask

  task automatic check_byte(input string req, input int p, input int c);
    logic [7:0] b;
    scan_byte(p, c, b);
    check(req, {24'h0, b}, {24'h0, exp_mem[p * COLS + c]});
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (whole run): actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; scan_en = 1'b0;
    addr = '0; wdata = '0; scan_x = '0; scan_y = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset values, R3 zero reads
    rd(A_IRQ, r);  check("R1 irq ctrl after reset", r, 32'h0);
    rd(A_MODE, r); check("R3 mode offset reads zero", r, 32'h0);

    // R2 interrupt-control register
    wr(A_IRQ, 32'hDEAD_BEEF);
    rd(A_IRQ, r);  check("R2 irq ctrl readback", r, 32'hDEAD_BEEF);
    rd(A_DATA, r); check("R3 data offset reads zero", r, 32'h0);
    rd(A_INST, r); check("R3 instr offset reads zero", r, 32'h0);
    rd(12'h184, r); check("R3 unused offset reads zero", r, 32'h0);

    // R1 cursor starts at page 0 column 0, R4 data magic
    wr(A_MODE, M_DATA);
    wr(A_DATA, 32'h5A);
    exp_mem[0] = 8'h5A;
    check_byte("R1 first store at page 0 col 0", 0, 0);

    // R7 fill every page through the instruction register
    for (int p = 0; p < PAGES; p++) begin
      wr(A_INST, 32'hB0 + 32'(p));
      for (int c = 0; c < COLS; c++) begin
        wr(A_DATA, {24'hFFFF_FF, pat(p, c)});
        exp_mem[p * COLS + c] = pat(p, c);
      end
    end
    // R10 sweep every pixel of every byte
    for (int p = 0; p < PAGES; p++)
      for (int c = 0; c < COLS; c++)
        check_byte("R7 R10 sweep", p, c);

    // R8 column wrap on page 3
    wr(A_INST, 32'hB3);
    for (int c = 0; c <= COLS; c++) begin
      wr(A_DATA, 32'(8'(c) ^ 8'hA5));
      exp_mem[3 * COLS + (c % COLS)] = 8'(c) ^ 8'hA5;
    end
    check_byte("R8 wrap overwrote col 0", 3, 0);
    check_byte("R8 col 1 intact", 3, 1);
    check_byte("R8 col 127", 3, 127);
    check_byte("R8 page 4 untouched", 4, 0);

    // R4 near-miss magic gives invalid mode, R9 writes ignored
    wr(A_MODE, 32'h0010_0012);
    wr(A_DATA, 32'h77);
    check_byte("R9 no store in invalid mode", 3, 1);
    wr(A_MODE, M_DATA);
    wr(A_DATA, 32'h42);
    exp_mem[3 * COLS + 1] = 8'h42;
    check_byte("R9 cursor held in invalid mode", 3, 1);
    check_byte("R9 next byte untouched", 3, 2);
    wr(A_MODE, 32'h1010_4011);
    wr(A_DATA, 32'h55);
    check_byte("R4 extra bits give invalid mode", 3, 2);

    // R6 command mode page select through the data register
    wr(A_MODE, M_CMD);
    wr(A_DATA, 32'hB5);
    wr(A_DATA, 32'h33);
    wr(A_DATA, 32'hAF);
    check_byte("R6 command-mode value not stored", 3, 2);
    wr(A_MODE, M_DATA);
    wr(A_DATA, 32'h99);
    exp_mem[5 * COLS] = 8'h99;
    check_byte("R6 page 5 selected in command mode", 5, 0);
    check_byte("R6 page 5 col 1 untouched", 5, 1);

    // R5 instruction register: out-of-range values ignored
    wr(A_INST, 32'hB8);
    wr(A_INST, 32'h0000_01B2);
    wr(A_DATA, 32'h6C);
    exp_mem[5 * COLS + 1] = 8'h6C;
    check_byte("R5 bad instr values ignored", 5, 1);
    wr(A_MODE, M_CMD);
    wr(A_INST, 32'hB6);
    wr(A_MODE, M_DATA);
    wr(A_DATA, 32'h1E);
    exp_mem[6 * COLS] = 8'h1E;
    check_byte("R5 instr page select in command mode", 6, 0);

    // R11 scan read and store in the same cycle
    @(negedge clk);
    wr_en = 1'b1; addr = A_DATA; wdata = 32'hC3;
    scan_en = 1'b1; scan_x = 7'd5; scan_y = 6'd2;
    @(negedge clk);
    wr_en = 1'b0; scan_en = 1'b0;
    check("R11 scan during store", {31'h0, scan_pix}, {31'h0, exp_mem[5][2]});
    exp_mem[6 * COLS + 1] = 8'hC3;
    check_byte("R11 store during scan", 6, 1);

    // R1 second reset: invalid mode, cursor home, irq cleared
    wr(A_IRQ, 32'h1234_5678);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    rd(A_IRQ, r); check("R1 irq ctrl cleared by reset", r, 32'h0);
    wr(A_DATA, 32'hEE);
    check_byte("R1 mode invalid after reset", 0, 0);
    wr(A_MODE, M_DATA);
    wr(A_DATA, 32'h11);
    exp_mem[0] = 8'h11;
    check_byte("R1 cursor home after reset", 0, 0);
    check_byte("R1 neighbour untouched", 0, 1);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule